// File: doc/BRIEF.md
# Five-Tap Polyphase Line Resizer

This block resizes or filters a single line of 8-bit pixels along one direction. A line is first streamed in and held in an internal line store. The block then produces a programmable number of output pixels. Each output pixel is a five-tap weighted sum of the stored pixels around a fixed-point source position. The weights come from one of sixteen coefficient sets, and the fraction of that position chooses the set. The same engine therefore acts as a plain filter when the step is 1.0 and as a resizer for any other step. To filter in two directions, run two passes; the second pass works on transposed data.

The position is an unsigned 16.16 accumulator. It starts at zero for each line and grows by the programmed step after every accepted output pixel. Taps that fall outside the line take the value of the nearest end pixel. Each sum is rounded, scaled down by 512 and clamped to the pixel range. The output stream can feed a later stage, such as colour conversion, directly. Coefficients are written one at a time through a small write port. They should be changed only while no line is in flight.

Top module: `hrz_resizer`

## Requirements
- R1: After reset, in_ready, out_valid and done are all low.
- R2: A start pulse accepted while idle or done makes the block take exactly cfg_in_len pixels, one per cycle with in_valid and in_ready both high. in_ready is high only during this intake and goes low after the last input pixel.
- R3: Output pixel k is clamp(((sum over t=0..4 of C[ph][t]*P[c+t-2]) + 256) >>> 9). Here c is the integer part (bits 31:16) of the position, ph is bits 15:12, and C[ph][t] is signed.
- R4: Output pixel k uses the position k*cfg_step. cfg_step is read as unsigned 16.16 fixed point and is captured at start.
- R5: A tap index below 0 reads pixel 0. A tap index above cfg_in_len-1 reads the last pixel of the line.
- R6: A rounded result below 0 gives 0, and one above 255 gives 255.
- R7: Reset loads every phase with the pass-through set (0, 0, 512, 0, 0), where tap 2 is the centre. With a step of 1.0 the output then equals the input.
- R8: With coef_we high, coef_value is written to phase coef_phase, tap coef_tap (0..4). A write with coef_tap of 5, 6 or 7 has no effect.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged on the next cycle.
- R10: Exactly cfg_out_len pixels are emitted. done rises in the cycle after the last one is accepted and stays high, with out_valid and in_ready low, until the next accepted start.
- R11: A start with cfg_in_len of 0, cfg_in_len above MAX_LEN or cfg_out_len of 0 is ignored, and the block stays in its current idle or done state.
- R12: out_valid first rises in the cycle right after the last input pixel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a line; lengths and step are captured |
| cfg_step | input | 32 | Position step per output pixel, unsigned 16.16 |
| cfg_in_len | input | LEN_W (7) | Input pixels in the line, 1..MAX_LEN |
| cfg_out_len | input | OUT_LEN_W (12) | Output pixels to produce, at least 1 |
| coef_we | input | 1 | Coefficient write strobe |
| coef_phase | input | 4 | Phase set being written |
| coef_tap | input | 3 | Tap being written, 0..4 |
| coef_value | input | 11 | Signed coefficient value |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block takes an input pixel |
| in_data | input | 8 | Input pixel |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_data | output | 8 | Output pixel |
| done | output | 1 | Line finished |

## Verification
An input handshake counts at the edge where both in_valid and in_ready are high. The first output pixel is on the ports one cycle after the last input is accepted. Each later pixel appears one cycle after the previous one is accepted, and done follows one cycle after the final acceptance. The bench drives and samples at the falling edge. It compares every output pixel with a bench-side model at the point where that pixel is offered. It checks out_valid and done at the first falling edge after the final input or output handshake. A stall cycle is checked against the value seen in the cycle before it.

// File: rtl/hrz_resizer_pkg.sv
// Shared constants and types for the five-tap polyphase line resizer.
// Assumes a fixed kernel of five taps with the centre at tap 2 and sixteen
// phases taken from the top fraction bits of a 16.16 position.
package hrz_resizer_pkg;
    localparam int PIX_W      = 8;
    localparam int COEF_W     = 11;
    localparam int NTAPS      = 5;
    localparam int CTR_TAP    = 2;
    localparam int TAP_W      = 3;
    localparam int PHASE_BITS = 4;
    localparam int NPHASES    = 1 << PHASE_BITS;
    localparam int INT_W      = 16;
    localparam int FRAC_W     = 16;
    localparam int POS_W      = INT_W + FRAC_W;
    localparam int RND_SHIFT  = 9;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [POS_W-1:0]         pos_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_EMIT,
        ST_DONE
    } rs_state_t;
endpackage

// File: rtl/hrz_coef_bank.sv
// Writable coefficient table: NPHASES sets of NTAPS signed weights.
// Reset loads the pass-through set in every phase. Writes to tap indices
// beyond the kernel are dropped. Read is combinational by phase.
module hrz_coef_bank
    import hrz_resizer_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PHASE_BITS-1:0] wr_phase,
    input  logic [TAP_W-1:0]      wr_tap,
    input  coef_t                 wr_value,
    input  logic [PHASE_BITS-1:0] rd_phase,
    output coef_t                 rd_coef [NTAPS]
);
    localparam coef_t            UNITY    = COEF_W'(1 << RND_SHIFT);
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NTAPS - 1);

    coef_t bank [NPHASES][NTAPS];

    // Table update: reset to pass-through, else single-entry write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPHASES; p++) begin
                for (int t = 0; t < NTAPS; t++) begin
                    bank[p][t] <= (t == CTR_TAP) ? UNITY : '0;
                end
            end
        end else if (wr_en && (wr_tap <= LAST_TAP)) begin
            bank[wr_phase][wr_tap] <= wr_value;
        end
    end

    for (genvar t = 0; t < NTAPS; t++) begin : g_rd
        assign rd_coef[t] = bank[rd_phase][t];
    end
endmodule

// File: rtl/hrz_line_store.sv
// Line store plus tap gather. Holds one input line; returns the five pixels
// around a centre index, replicating the end pixels outside 0..last_idx.
// Assumes last_idx < MAX_LEN; storage has no reset.
module hrz_line_store
    import hrz_resizer_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_addr,
    input  pix_t             wr_data,
    input  logic [INT_W-1:0] centre,
    input  logic [LEN_W-1:0] last_idx,
    output pix_t             taps [NTAPS]
);
    localparam int IDX_W = $clog2(MAX_LEN);
    localparam int SW    = INT_W + 2;

    pix_t mem [MAX_LEN];

    // Storage write during intake.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    logic signed [SW-1:0] last_s;
    assign last_s = $signed({{(SW-LEN_W){1'b0}}, last_idx});

    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        logic signed [SW-1:0] raw;
        logic [IDX_W-1:0]     sel;
        logic                 unused_hi;
        // Tap index with edge replication.
        always_comb begin
            raw = $signed({2'b00, centre}) + $signed(SW'(t)) - $signed(SW'(CTR_TAP));
            if (raw < 0)            sel = '0;
            else if (raw > last_s)  sel = last_idx[IDX_W-1:0];
            else                    sel = raw[IDX_W-1:0];
        end
        assign unused_hi = ^raw[SW-1:IDX_W];
        assign taps[t]   = mem[sel];
    end
endmodule

// File: rtl/hrz_mac.sv
// Five-tap multiply-accumulate with round-half-up, arithmetic shift and
// clamp to the pixel range. Purely combinational.
module hrz_mac
    import hrz_resizer_pkg::*;
(
    input  pix_t  taps  [NTAPS],
    input  coef_t coefs [NTAPS],
    output pix_t  result
);
    localparam int ACC_W = PIX_W + COEF_W + 1 + $clog2(NTAPS);
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1 << (RND_SHIFT - 1));
    localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] scaled;

    // Weighted sum, rounding and saturation.
    always_comb begin
        sum = RND;
        for (int t = 0; t < NTAPS; t++) begin
            sum = sum + ACC_W'($signed({1'b0, taps[t]})) * ACC_W'(coefs[t]);
        end
        scaled = sum >>> RND_SHIFT;
        if (scaled < 0)          result = '0;
        else if (scaled > PMAX)  result = '1;
        else                     result = scaled[PIX_W-1:0];
    end
endmodule

// File: rtl/hrz_resizer.sv
// Top of the polyphase line resizer. Sequencer: idle -> intake of one line
// -> emission of out_len pixels stepping a 16.16 position -> done.
// Assumes coefficients are written only while no line is in flight.
module hrz_resizer
    import hrz_resizer_pkg::*;
#(
    parameter int MAX_LEN   = 64,
    parameter int LEN_W     = $clog2(MAX_LEN + 1),
    parameter int OUT_LEN_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [POS_W-1:0]      cfg_step,
    input  logic [LEN_W-1:0]      cfg_in_len,
    input  logic [OUT_LEN_W-1:0]  cfg_out_len,
    input  logic                  coef_we,
    input  logic [PHASE_BITS-1:0] coef_phase,
    input  logic [TAP_W-1:0]      coef_tap,
    input  logic [COEF_W-1:0]     coef_value,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [PIX_W-1:0]      in_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [PIX_W-1:0]      out_data,
    output logic                  done
);
    localparam logic [LEN_W-1:0] MAX_LEN_V = LEN_W'(MAX_LEN);

    rs_state_t             state;
    logic [LEN_W-1:0]      wr_cnt;
    logic [LEN_W-1:0]      in_len_q;
    logic [OUT_LEN_W-1:0]  out_cnt;
    logic [OUT_LEN_W-1:0]  out_len_q;
    pos_t                  step_q;
    pos_t                  pos;
    logic                  cfg_ok;
    logic                  unused_frac;

    coef_t cur_coef [NTAPS];
    pix_t  cur_taps [NTAPS];

    assign cfg_ok = (cfg_in_len != '0) && (cfg_in_len <= MAX_LEN_V) && (cfg_out_len != '0);

    // Sequencer, counters and position accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            wr_cnt    <= '0;
            in_len_q  <= '0;
            out_cnt   <= '0;
            out_len_q <= '0;
            step_q    <= '0;
            pos       <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start && cfg_ok) begin
                        state     <= ST_LOAD;
                        wr_cnt    <= '0;
                        out_cnt   <= '0;
                        pos       <= '0;
                        in_len_q  <= cfg_in_len;
                        out_len_q <= cfg_out_len;
                        step_q    <= cfg_step;
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        wr_cnt <= wr_cnt + LEN_W'(1);
                        if (wr_cnt == in_len_q - LEN_W'(1)) state <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        pos     <= pos + step_q;
                        out_cnt <= out_cnt + OUT_LEN_W'(1);
                        if (out_cnt == out_len_q - OUT_LEN_W'(1)) state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_ready    = (state == ST_LOAD);
    assign out_valid   = (state == ST_EMIT);
    assign done        = (state == ST_DONE);
    assign unused_frac = ^pos[FRAC_W-PHASE_BITS-1:0];

    hrz_coef_bank u_coef_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (coef_we),
        .wr_phase (coef_phase),
        .wr_tap   (coef_tap),
        .wr_value (coef_value),
        .rd_phase (pos[FRAC_W-1 -: PHASE_BITS]),
        .rd_coef  (cur_coef)
    );

    hrz_line_store #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W)
    ) u_line_store (
        .clk      (clk),
        .wr_en    (in_ready && in_valid),
        .wr_addr  (wr_cnt),
        .wr_data  (in_data),
        .centre   (pos[POS_W-1:FRAC_W]),
        .last_idx (in_len_q - LEN_W'(1)),
        .taps     (cur_taps)
    );

    hrz_mac u_mac (
        .taps   (cur_taps),
        .coefs  (cur_coef),
        .result (out_data)
    );
endmodule

// File: rtl/hrz_resizer_checker.sv
// Protocol checker for the resizer ports; bound to every hrz_resizer.
module hrz_resizer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       done
);
    // R2: intake never overlaps emission or completion.
    assert_intake_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid && !done));

    // R9: a stalled output holds its value.
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: done rises only after an output handshake.
    assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready));

    // R10: done is quiet on both streams.
    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && !in_ready));

    // R12: emission begins right after an input handshake.
    assert_first_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind hrz_resizer hrz_resizer_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done)
);

// File: tb/hrz_resizer_bench.sv
// Self-checking bench: directed lines plus seeded random lines, compared
// with a bench-side model of the filter.
module hrz_resizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_step = '0;
    logic [6:0]  cfg_in_len = '0;
    logic [11:0] cfg_out_len = '0;
    logic        coef_we = 1'b0;
    logic [3:0]  coef_phase = '0;
    logic [2:0]  coef_tap = '0;
    logic [10:0] coef_value = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cm [16][5];
    int px [64];

    always #5 clk = ~clk;

    hrz_resizer u_hrz_resizer (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_step(cfg_step),
        .cfg_in_len(cfg_in_len), .cfg_out_len(cfg_out_len),
        .coef_we(coef_we), .coef_phase(coef_phase), .coef_tap(coef_tap),
        .coef_value(coef_value), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int k, input int step, input int n);
        longint pos;
        int c, ph, s, idx, r;
        pos = longint'(k) * longint'(unsigned'(step));
        c   = int'(pos >> 16);
        ph  = int'((pos >> 12) & 15);
        s   = 256;
        for (int t = 0; t < 5; t++) begin
            idx = c + t - 2;
            if (idx < 0) idx = 0;
            if (idx > n - 1) idx = n - 1;
            s += cm[ph][t] * px[idx];
        end
        r = s >>> 9;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic wcoef(input int ph, input int tap, input int val);
        @(negedge clk);
        coef_we = 1'b1; coef_phase = 4'(ph); coef_tap = 3'(tap); coef_value = 11'(val);
        @(negedge clk);
        coef_we = 1'b0;
        if (tap < 5) cm[ph][tap] = val;
    endtask

    task automatic set_all(input int a, input int b, input int c, input int d, input int e);
        for (int p = 0; p < 16; p++) begin
            wcoef(p, 0, a); wcoef(p, 1, b); wcoef(p, 2, c); wcoef(p, 3, d); wcoef(p, 4, e);
        end
    endtask

    task automatic run_line(input int n, input int m, input int step, input string tag);
        int i, k, pdata;
        bit pstall;
        @(negedge clk);
        start = 1'b1; cfg_in_len = 7'(n); cfg_out_len = 12'(m); cfg_step = 32'(step);
        @(negedge clk);
        start = 1'b0;
        i = 0;
        while (i < n) begin
            in_valid = ($urandom % 4) != 0;
            in_data  = 8'(px[i]);
            #1;
            if (!in_ready) chk(1'b0, "R2 in_ready", 0, 1);
            if (in_valid) i++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        #1;
        chk(out_valid && !in_ready, "R12 out_valid after last input", int'(out_valid), 1);
        k = 0; pstall = 1'b0; pdata = 0;
        while (k < m) begin
            out_ready = ($urandom % 3) != 0;
            #1;
            if (pstall) chk(int'(out_data) == pdata, "R9 stall hold", int'(out_data), pdata);
            chk(out_valid && int'(out_data) == model(k, step, n), tag,
                int'(out_data), model(k, step, n));
            pstall = !out_ready;
            pdata  = int'(out_data);
            if (out_ready) k++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        #1;
        chk(done && !out_valid && !in_ready, "R10 done after last output", int'(done), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed, n, m, st;
        seed = int'($urandom(32'd2718));
        for (int p = 0; p < 16; p++)
            for (int t = 0; t < 5; t++) cm[p][t] = (t == 2) ? 512 : 0;
        repeat (3) @(negedge clk);
        #1;
        chk(!in_ready && !out_valid && !done, "R1 reset outputs", int'(in_ready | out_valid | done), 0);
        rst_n = 1'b1;

        // R7: pass-through after reset
        for (int i = 0; i < 64; i++) px[i] = int'($urandom % 256);
        run_line(20, 20, 32'h0001_0000, "R7 identity");

        // R8: out-of-range tap writes ignored
        wcoef(0, 5, 700); wcoef(0, 7, -300);
        run_line(12, 12, 32'h0001_0000, "R8 ignored tap write");

        // R11: zero lengths ignored while done
        @(negedge clk);
        start = 1'b1; cfg_in_len = 7'd4; cfg_out_len = 12'd0;
        @(negedge clk);
        start = 1'b0; #1;
        chk(done && !in_ready, "R11 zero out_len", int'(in_ready), 0);
        @(negedge clk);
        start = 1'b1; cfg_in_len = 7'd0; cfg_out_len = 12'd5;
        @(negedge clk);
        start = 1'b0; #1;
        chk(done && !in_ready, "R11 zero in_len", int'(in_ready), 0);

        // R8/R3: random per-phase coefficient sets summing to 512
        for (int p = 0; p < 16; p++) begin
            int s;
            s = 0;
            for (int t = 0; t < 5; t++) begin
                if (t != 2) begin
                    cm[p][t] = int'($urandom % 201) - 100;
                    s += cm[p][t];
                end
            end
            cm[p][2] = 512 - s;
            for (int t = 0; t < 5; t++) wcoef(p, t, cm[p][t]);
        end
        run_line(40, 20, 32'h0002_0000, "R3 downscale by 2");
        run_line(30, 20, 32'h0001_8000, "R4 step 1.5");
        run_line(16, 40, 32'h0000_6666, "R5 upscale edge replicate");
        run_line(1, 3, 32'h0000_8000, "R5 single pixel line");
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 64; i++) px[i] = int'($urandom % 256);
            n  = 5 + int'($urandom % 60);
            m  = 1 + int'($urandom % 60);
            st = 32'h4000 + int'($urandom % 32'h2C000);
            run_line(n, m, st, "R4 random step");
        end

        // R6: overshooting kernel on alternating extremes
        set_all(-300, 0, 1000, 0, -188);
        for (int i = 0; i < 64; i++) px[i] = ((i / 2) % 2 == 0) ? 255 : 0;
        px[10] = 0; px[11] = 255;
        run_line(24, 30, 32'h0000_C000, "R6 clamp");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule